// File: doc/BRIEF.md
# Posted Write Data Staging Buffer

This block sits between a serial link's frame decoder and a DRAM write datapath. Write data arrives slowly, one 72-bit beat per data frame. The block gathers four such beats into one 288-bit entry and keeps up to eight complete entries. Write commands arrive on their own strobe and carry neither data nor a tag. Each accepted command claims the oldest complete entry that no earlier command has claimed. The entry then leaves toward the memory side as a burst of four beats on back-to-back cycles.

The block reports how many complete entries it holds. It raises a one-cycle flag when a write command finds nothing to drain. It raises another one-cycle flag when a data beat is dropped because storage is full. A synchronous flush input returns the buffer to its empty state without a reset.

Top module: `wr_stage_buf`

## Requirements
- R1: After rst_ni is released, level_o is 0, and burst_valid_o, overflow_o and underflow_o are all low.
- R2: Each cycle with wdata_valid_i high stores one beat. Beats are grouped in fours into an entry. level_o rises by one in the cycle after the fourth beat of an entry is taken. A partly filled entry is not counted.
- R3: A wcmd_i pulse is accepted only when the held complete entries outnumber the commands already accepted. An accepted command claims the oldest unclaimed complete entry, with no tag of any kind.
- R4: A claimed entry is emitted as four beats on consecutive cycles with burst_valid_o high, in arrival order. burst_first_o marks the first beat and burst_last_o marks the fourth. When no burst is pending, the first beat appears in the cycle after the command. Queued commands produce bursts with no idle cycle between them.
- R5: level_o counts the complete entries held, at most 8. An entry stops counting in the cycle after its fourth beat was presented.
- R6: A command with no unclaimed complete entry raises underflow_o for one cycle, in the next cycle. It produces no burst and does not change later bursts.
- R7: A beat that would start a new entry while 8 complete entries are held raises overflow_o for one cycle, in the next cycle. The beat is discarded and the stored entries are unchanged. A slot frees only when its burst ends.
- R8: A command in the same cycle as the fourth beat of an entry sees only the entries that were complete before that cycle.
- R9: flush_i, sampled on a clock edge, discards all entries, the partial entry and all pending commands. In the next cycle level_o is 0 and burst_valid_o, overflow_o and underflow_o are low. Data and command inputs in the flush cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous clear of all contents |
| wdata_valid_i | input | 1 | One write-data beat present |
| wdata_i | input | 72 | Write-data beat |
| wcmd_i | input | 1 | Write command strobe |
| burst_valid_o | output | 1 | Burst beat valid |
| burst_data_o | output | 72 | Burst beat data |
| burst_first_o | output | 1 | First beat of a burst |
| burst_last_o | output | 1 | Last beat of a burst |
| level_o | output | 4 | Complete entries held (0 to 8) |
| overflow_o | output | 1 | Beat dropped in the previous cycle |
| underflow_o | output | 1 | Command refused in the previous cycle |

## Verification
A beat counter that slips shows up at the ports within four data beats. Either level_o rises at the wrong beat, or the next burst carries beats from two different entries. A drifted read pointer or claim count shows up one cycle after the next command. The symptom is a burst with the wrong data, a missing or extra underflow pulse, or burst_valid_o staying high past burst_last_o. A wrong full count appears on the first beat offered at eight entries, as a missing overflow pulse or as data that later reappears in a burst.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  localparam int unsigned WSB_BEAT_W = 72;
  localparam int unsigned WSB_BEATS  = 4;
  localparam int unsigned WSB_DEPTH  = 8;

  typedef struct packed {
    logic ovf;
    logic unf;
  } wsb_evt_t;
endpackage

// File: rtl/wsb_fill.sv
module wsb_fill #(
  parameter int unsigned BEATS = 4,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned BC_W  = $clog2(BEATS),
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             valid_i,
  input  logic             full_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [BC_W-1:0]  wr_beat_o,
  output logic             done_o,
  output logic             ovf_o
);
  logic [BC_W-1:0]  beat_q;
  logic [PTR_W-1:0] ptr_q;

  // a new entry needs a free slot; a partial entry already owns one
  assign ovf_o     = valid_i && !flush_i && (beat_q == '0) && full_i;
  assign wr_en_o   = valid_i && !flush_i && !ovf_o;
  assign done_o    = wr_en_o && (beat_q == BC_W'(BEATS - 1));
  assign wr_ptr_o  = ptr_q;
  assign wr_beat_o = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      ptr_q  <= '0;
    end else if (flush_i) begin
      beat_q <= '0;
      ptr_q  <= '0;
    end else if (wr_en_o) begin
      beat_q <= beat_q + 1'b1;
      if (done_o) ptr_q <= ptr_q + 1'b1;
    end
  end

  AST_OVF_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (beat_q == '0) && $stable(ptr_q)); // R7
endmodule

// File: rtl/wsb_mem.sv
module wsb_mem #(
  parameter int unsigned BEAT_W = 72,
  parameter int unsigned BEATS  = 4,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned BC_W  = $clog2(BEATS),
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned SLOTS = DEPTH * BEATS
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [BC_W-1:0]   wr_beat_i,
  input  logic [BEAT_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  input  logic [BC_W-1:0]   rd_beat_i,
  output logic [BEAT_W-1:0] rd_data_o
);
  logic [BEAT_W-1:0] mem_q [SLOTS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[{wr_ptr_i, wr_beat_i}] <= wr_data_i;
  end

  assign rd_data_o = mem_q[{rd_ptr_i, rd_beat_i}];
endmodule

// File: rtl/wsb_track.sv
module wsb_track #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             done_i,
  input  logic             cmd_i,
  input  logic             release_i,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             active_o,
  output logic             unf_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] cred_q;
  logic             accept;

  // held entries minus claimed entries, both before this edge
  assign unf_o    = cmd_i && !flush_i && (count_q == cred_q);
  assign accept   = cmd_i && !flush_i && (count_q != cred_q);
  assign full_o   = (count_q == CNT_W'(DEPTH));
  assign active_o = (cred_q != '0);
  assign count_o  = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      cred_q  <= '0;
    end else if (flush_i) begin
      count_q <= '0;
      cred_q  <= '0;
    end else begin
      count_q <= count_q + CNT_W'(done_i) - CNT_W'(release_i);
      cred_q  <= cred_q + CNT_W'(accept) - CNT_W'(release_i);
    end
  end

  AST_CLAIM_LE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cred_q <= count_q); // R3
  AST_LEVEL_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH)); // R5
  AST_RELEASE_NEEDS_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> active_o); // R4
endmodule

// File: rtl/wsb_drain.sv
module wsb_drain #(
  parameter int unsigned BEATS = 4,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned BC_W  = $clog2(BEATS),
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             active_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [BC_W-1:0]  rd_beat_o,
  output logic             valid_o,
  output logic             first_o,
  output logic             last_o,
  output logic             release_o
);
  logic [BC_W-1:0]  beat_q;
  logic [PTR_W-1:0] ptr_q;

  assign valid_o   = active_i;
  assign first_o   = active_i && (beat_q == '0);
  assign last_o    = active_i && (beat_q == BC_W'(BEATS - 1));
  assign release_o = last_o && !flush_i;
  assign rd_ptr_o  = ptr_q;
  assign rd_beat_o = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      ptr_q  <= '0;
    end else if (flush_i) begin
      beat_q <= '0;
      ptr_q  <= '0;
    end else if (active_i) begin
      beat_q <= beat_q + 1'b1;
      if (last_o) ptr_q <= ptr_q + 1'b1;
    end
  end

  AST_BURST_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni || flush_i)
    valid_o && !last_o |=> valid_o && !first_o); // R4
  AST_FIRST_LAST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({first_o, last_o})); // R4
endmodule

// File: rtl/wr_stage_buf.sv
module wr_stage_buf
  import wsb_pkg::*;
#(
  parameter int unsigned BEAT_W = WSB_BEAT_W,
  parameter int unsigned BEATS  = WSB_BEATS,
  parameter int unsigned DEPTH  = WSB_DEPTH,
  localparam int unsigned BC_W  = $clog2(BEATS),
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wdata_valid_i,
  input  logic [BEAT_W-1:0] wdata_i,
  input  logic              wcmd_i,
  output logic              burst_valid_o,
  output logic [BEAT_W-1:0] burst_data_o,
  output logic              burst_first_o,
  output logic              burst_last_o,
  output logic [CNT_W-1:0]  level_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  logic             wr_en, done, full, active, rel;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [BC_W-1:0]  wr_beat, rd_beat;
  wsb_evt_t         evt_d, evt_q;

  wsb_fill #(.BEATS(BEATS), .DEPTH(DEPTH)) u_fill (
    .clk_i, .rst_ni, .flush_i,
    .valid_i  (wdata_valid_i),
    .full_i   (full),
    .wr_en_o  (wr_en),
    .wr_ptr_o (wr_ptr),
    .wr_beat_o(wr_beat),
    .done_o   (done),
    .ovf_o    (evt_d.ovf)
  );

  wsb_mem #(.BEAT_W(BEAT_W), .BEATS(BEATS), .DEPTH(DEPTH)) u_mem (
    .clk_i,
    .wr_en_i  (wr_en),
    .wr_ptr_i (wr_ptr),
    .wr_beat_i(wr_beat),
    .wr_data_i(wdata_i),
    .rd_ptr_i (rd_ptr),
    .rd_beat_i(rd_beat),
    .rd_data_o(burst_data_o)
  );

  wsb_track #(.DEPTH(DEPTH)) u_track (
    .clk_i, .rst_ni, .flush_i,
    .done_i   (done),
    .cmd_i    (wcmd_i),
    .release_i(rel),
    .count_o  (level_o),
    .full_o   (full),
    .active_o (active),
    .unf_o    (evt_d.unf)
  );

  wsb_drain #(.BEATS(BEATS), .DEPTH(DEPTH)) u_drain (
    .clk_i, .rst_ni, .flush_i,
    .active_i (active),
    .rd_ptr_o (rd_ptr),
    .rd_beat_o(rd_beat),
    .valid_o  (burst_valid_o),
    .first_o  (burst_first_o),
    .last_o   (burst_last_o),
    .release_o(rel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      evt_q <= '0;
    else if (flush_i) evt_q <= '0;
    else              evt_q <= evt_d;
  end

  assign overflow_o  = evt_q.ovf;
  assign underflow_o = evt_q.unf;

  AST_UNF_NO_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcmd_i && !flush_i && (level_o == '0) |=> !burst_valid_o && underflow_o); // R6
  AST_FLUSH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_o == '0) && !burst_valid_o && !overflow_o && !underflow_o); // R9
  AST_OVF_HOLDS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_valid_i && !flush_i && (level_o == CNT_W'(DEPTH)) && !burst_last_o
      |=> level_o == CNT_W'(DEPTH)); // R7
endmodule

// File: tb/tb_wr_stage_buf.sv
module tb_wr_stage_buf;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        wdata_valid_i = 1'b0;
  logic [71:0] wdata_i = '0;
  logic        wcmd_i = 1'b0;
  logic        burst_valid_o, burst_first_o, burst_last_o;
  logic [71:0] burst_data_o;
  logic [3:0]  level_o;
  logic        overflow_o, underflow_o;

  wr_stage_buf dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  int          held = 0, cred = 0, bidx = 0;
  logic        prev_last = 1'b0;
  logic [71:0] partial[$];
  logic [71:0] expq[$];
  logic        e_ovf = 1'b0, e_unf = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [71:0] mk(input int e, input int b);
    return {16'(e), 8'(b), 48'(e * 1009 + b * 77) ^ 48'h3c3c_a5a5_0f0f};
  endfunction

  task automatic step(input logic v, input logic [71:0] d, input logic c, input logic f);
    bit comp, acc, rel;
    @(negedge clk_i);
    wdata_valid_i = v; wdata_i = d; wcmd_i = c; flush_i = f;
    comp = 1'b0; acc = 1'b0; rel = prev_last;
    if (f) begin
      partial.delete(); expq.delete();
      held = 0; cred = 0; bidx = 0; e_ovf = 1'b0; e_unf = 1'b0; rel = 1'b0;
    end else begin
      e_unf = c && (held == cred);               // R8: pre-edge view only
      acc   = c && !e_unf;
      e_ovf = v && (partial.size() == 0) && (held == 8);
      if (v && !e_ovf) begin
        partial.push_back(d);
        if (partial.size() == 4) begin
          foreach (partial[k]) expq.push_back(partial[k]);
          partial.delete();
          comp = 1'b1;
        end
      end
      held = held + int'(comp) - int'(rel);
      cred = cred + int'(acc) - int'(rel);
    end
    @(posedge clk_i); #1;
    chk(level_o == 4'(held), "R2 R5 level", 72'(level_o), 72'(held));
    chk(burst_valid_o == (cred > 0), "R4 valid", 72'(burst_valid_o), 72'(cred > 0));
    chk(overflow_o == e_ovf, "R7 overflow", 72'(overflow_o), 72'(e_ovf));
    chk(underflow_o == e_unf, "R6 underflow", 72'(underflow_o), 72'(e_unf));
    prev_last = 1'b0;
    if (burst_valid_o) begin
      if (expq.size() > 0) begin
        chk(burst_data_o == expq[0], "R3 R4 data", burst_data_o, expq[0]);
        void'(expq.pop_front());
      end else begin
        chk(1'b0, "R3 data without entry", burst_data_o, '0);
      end
      chk(burst_first_o == (bidx == 0), "R4 first", 72'(burst_first_o), 72'(bidx == 0));
      chk(burst_last_o == (bidx == 3), "R4 last", 72'(burst_last_o), 72'(bidx == 3));
      prev_last = burst_last_o;
      bidx = (bidx + 1) % 4;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic put_entry(input int e);
    for (int b = 0; b < 4; b++) step(1'b1, mk(e, b), 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // R1 reset state
    chk(level_o == 0, "R1 level", 72'(level_o), 0);
    chk(!burst_valid_o, "R1 valid", 72'(burst_valid_o), 0);
    chk(!overflow_o, "R1 overflow", 72'(overflow_o), 0);
    chk(!underflow_o, "R1 underflow", 72'(underflow_o), 0);

    // single entry, then its command; burst follows in the next cycle (R4)
    put_entry(1);
    step(1'b0, '0, 1'b1, 1'b0);
    chk(burst_first_o && burst_data_o == mk(1, 0), "R4 start next cycle", burst_data_o, mk(1, 0));
    idle(6);

    // R6 command on empty buffer
    step(1'b0, '0, 1'b1, 1'b0);
    chk(underflow_o && !burst_valid_o, "R6 empty cmd", 72'({underflow_o, burst_valid_o}), 72'(2'b10));
    idle(5);

    // R2 partial entry does not satisfy a command
    for (int b = 0; b < 3; b++) step(1'b1, mk(2, b), 1'b0, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0);
    chk(underflow_o, "R2 partial refused", 72'(underflow_o), 1);
    // R8 command together with the completing beat
    step(1'b1, mk(2, 3), 1'b1, 1'b0);
    chk(underflow_o && level_o == 1, "R8 same-cycle cmd", 72'({underflow_o, level_o}), 72'(5'b10001));
    step(1'b0, '0, 1'b1, 1'b0);
    idle(6);

    // R7 fill all slots, offer one more beat, then drain back to back
    for (int e = 10; e < 18; e++) put_entry(e);
    chk(level_o == 8, "R5 full level", 72'(level_o), 8);
    step(1'b1, mk(99, 0), 1'b0, 1'b0);
    chk(overflow_o, "R7 drop", 72'(overflow_o), 1);
    for (int e = 0; e < 8; e++) step(1'b0, '0, 1'b1, 1'b0);
    idle(30);
    chk(level_o == 0 && expq.size() == 0, "R3 all drained", 72'(level_o), 0);

    // interleaved sweep of data and command rates
    for (int gap = 0; gap < 4; gap++) begin
      for (int i = 0; i < 48; i++)
        step(((i + gap) % 5) != 0, mk(100 + gap * 64 + i / 4, i % 4), (i % (gap + 3)) == 0, 1'b0);
      for (int j = 0; j < 10; j++) begin
        step(1'b0, '0, 1'b1, 1'b0);
        idle(4);
      end
    end

    // R9 flush with a partial entry, held entries and a burst in flight
    put_entry(40);
    put_entry(41);
    step(1'b1, mk(42, 0), 1'b1, 1'b0);
    step(1'b1, mk(42, 1), 1'b0, 1'b0);
    step(1'b1, mk(43, 0), 1'b1, 1'b1);
    chk(level_o == 0 && !burst_valid_o, "R9 flush", 72'({burst_valid_o, level_o}), 0);
    put_entry(44);
    step(1'b0, '0, 1'b1, 1'b0);
    chk(burst_data_o == mk(44, 0), "R9 fresh after flush", burst_data_o, mk(44, 0));
    idle(8);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule